// File: doc/BRIEF.md
# Interrupt Pending and Take-Interrupt Gate

This block keeps a small vector of pending interrupt lines and decides, every cycle, whether the processor core has to enter its interrupt handler. Lines become pending through single-line post requests and stop being pending through single-line clear requests or a clear-all request. A built-in timer compare also marks a line as pending. A run-time routing field selects which line the timer uses.

The take-interrupt decision combines the pending vector with a per-line mask and three status flags. The flags are a global enable, an error-level flag and an exception-level flag. Either level flag, while set, holds interrupts off. The counter and compare registers, exception vectoring and register access decoding live outside this block. It only receives their values.

Top module: `irq_cause_gate`

## Requirements
- R1: While rst_ni is low, pend_o is all zeros and take_irq_o is low.
- R2: A post request (post_vld_i high, post_idx_i = n, n in 0..7) sets bit n of pend_o at the next clock edge and leaves every other bit unchanged.
- R3: A clear request (clr_vld_i high, clr_idx_i = n, n in 0..7) clears bit n only. If a post and a clear name the same line in one cycle, the clear wins.
- R4: clr_all_i high makes pend_o all zeros at the next edge, whatever post or clear requests arrive with it.
- R5: A valid post or clear whose 4-bit index is 8..15 leaves pend_o unchanged. It drives req_err_o high in the same cycle, combinationally.
- R6: A timer match happens when count_i equals compare_i and count_i is nonzero. A match sets pend_o bit tmr_route_i at the next edge. When count_i is zero, no match happens.
- R7: A timer match in the same cycle as clr_all_i leaves only the routed timer bit set.
- R8: take_irq_o is high only when (pend_o & im_i) is nonzero.
- R9: take_irq_o also requires ie_i = 1, erl_i = 0 and exl_i = 0. When these hold and R8's condition holds, take_irq_o is high.
- R10: take_irq_o is combinational from the registered pend_o. After a post is captured at an edge, it is high in the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| post_vld_i | input | 1 | Post request valid |
| post_idx_i | input | 4 | Line index of the post request |
| clr_vld_i | input | 1 | Clear request valid |
| clr_idx_i | input | 4 | Line index of the clear request |
| clr_all_i | input | 1 | Clear every pending line |
| ie_i | input | 1 | Global interrupt enable |
| erl_i | input | 1 | Error level flag, blocks interrupts |
| exl_i | input | 1 | Exception level flag, blocks interrupts |
| im_i | input | 8 | Per-line interrupt mask, 1 = enabled |
| count_i | input | 32 | Current timer count value |
| compare_i | input | 32 | Timer compare value |
| tmr_route_i | input | 3 | Line that a timer match sets |
| pend_o | output | 8 | Pending vector |
| take_irq_o | output | 1 | Core must take an interrupt |
| req_err_o | output | 1 | A valid request has an out-of-range index |

## Verification
The bench builds the block with its default parameters: eight lines, 4-bit request indices and a 32-bit timer. With 4-bit indices, the out-of-range values 8..15 can be driven, so the error path and the unchanged vector can be exercised. The 3-bit routing field covers every line, so timer matches can land on low, middle and high bits. The bench keeps the timer values small. The zero-count rule and the clear-all-versus-timer ordering are tested directly.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int unsigned NUM_LINES_DEF = 8;
  localparam int unsigned IDX_W_DEF     = 4;
  localparam int unsigned TMR_W_DEF     = 32;

  function automatic int unsigned route_w(input int unsigned lines);
    return (lines > 1) ? $clog2(lines) : 1;
  endfunction
endpackage

// File: rtl/irq_req_decode.sv
module irq_req_decode #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned IDX_W     = 4
) (
  input  logic                 vld_i,
  input  logic [IDX_W-1:0]     idx_i,
  output logic [NUM_LINES-1:0] mask_o,
  output logic                 err_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign mask_o[g] = vld_i && (idx_i == IDX_W'(g));
  end

  assign err_o = vld_i && (idx_i > LAST_IDX);
endmodule

// File: rtl/irq_timer_match.sv
module irq_timer_match #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned TMR_W     = 32,
  parameter int unsigned RW        = 3
) (
  input  logic [TMR_W-1:0]     count_i,
  input  logic [TMR_W-1:0]     compare_i,
  input  logic [RW-1:0]        route_i,
  output logic [NUM_LINES-1:0] set_o
);
  logic hit;

  // a zero count never matches
  assign hit = (count_i != '0) && (count_i == compare_i);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_route
    assign set_o[g] = hit && (route_i == RW'(g));
  end
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] post_mask_i,
  input  logic [NUM_LINES-1:0] clr_mask_i,
  input  logic                 clr_all_i,
  input  logic [NUM_LINES-1:0] tmr_set_i,
  output logic [NUM_LINES-1:0] pend_o
);
  logic [NUM_LINES-1:0] pend_q, pend_d, kept;

  // order: post, then clear, then clear-all, then timer set
  always_comb begin
    kept   = (pend_q | post_mask_i) & ~clr_mask_i;
    pend_d = (clr_all_i ? '0 : kept) | tmr_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_take_gate.sv
module irq_take_gate #(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic [NUM_LINES-1:0] pend_i,
  input  logic [NUM_LINES-1:0] im_i,
  input  logic                 ie_i,
  input  logic                 erl_i,
  input  logic                 exl_i,
  output logic                 take_o
);
  logic open_q;
  assign open_q = ie_i && !erl_i && !exl_i;
  assign take_o = open_q && |(pend_i & im_i);
endmodule

// File: rtl/irq_cause_gate.sv
module irq_cause_gate
  import irq_cause_pkg::*;
#(
  parameter int unsigned NUM_LINES = NUM_LINES_DEF,
  parameter int unsigned IDX_W     = IDX_W_DEF,
  parameter int unsigned TMR_W     = TMR_W_DEF,
  parameter int unsigned RW        = route_w(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 post_vld_i,
  input  logic [IDX_W-1:0]     post_idx_i,
  input  logic                 clr_vld_i,
  input  logic [IDX_W-1:0]     clr_idx_i,
  input  logic                 clr_all_i,
  input  logic                 ie_i,
  input  logic                 erl_i,
  input  logic                 exl_i,
  input  logic [NUM_LINES-1:0] im_i,
  input  logic [TMR_W-1:0]     count_i,
  input  logic [TMR_W-1:0]     compare_i,
  input  logic [RW-1:0]        tmr_route_i,
  output logic [NUM_LINES-1:0] pend_o,
  output logic                 take_irq_o,
  output logic                 req_err_o
);
  logic [NUM_LINES-1:0] post_mask, clr_mask, tmr_set;
  logic                 post_err, clr_err;

  irq_req_decode #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) i_post_dec (
    .vld_i(post_vld_i), .idx_i(post_idx_i), .mask_o(post_mask), .err_o(post_err)
  );

  irq_req_decode #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) i_clr_dec (
    .vld_i(clr_vld_i), .idx_i(clr_idx_i), .mask_o(clr_mask), .err_o(clr_err)
  );

  irq_timer_match #(.NUM_LINES(NUM_LINES), .TMR_W(TMR_W), .RW(RW)) i_tmr (
    .count_i(count_i), .compare_i(compare_i), .route_i(tmr_route_i), .set_o(tmr_set)
  );

  irq_pend_reg #(.NUM_LINES(NUM_LINES)) i_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .post_mask_i(post_mask), .clr_mask_i(clr_mask),
    .clr_all_i(clr_all_i), .tmr_set_i(tmr_set), .pend_o(pend_o)
  );

  irq_take_gate #(.NUM_LINES(NUM_LINES)) i_gate (
    .pend_i(pend_o), .im_i(im_i), .ie_i(ie_i), .erl_i(erl_i), .exl_i(exl_i),
    .take_o(take_irq_o)
  );

  assign req_err_o = post_err || clr_err;
endmodule

// File: rtl/irq_cause_chk.sv
module irq_cause_chk #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned TMR_W     = 32,
  parameter int unsigned RW        = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 post_vld_i,
  input logic [IDX_W-1:0]     post_idx_i,
  input logic                 clr_vld_i,
  input logic [IDX_W-1:0]     clr_idx_i,
  input logic                 clr_all_i,
  input logic                 ie_i,
  input logic                 erl_i,
  input logic                 exl_i,
  input logic [NUM_LINES-1:0] im_i,
  input logic [TMR_W-1:0]     count_i,
  input logic [TMR_W-1:0]     compare_i,
  input logic [RW-1:0]        tmr_route_i,
  input logic [NUM_LINES-1:0] pend_o,
  input logic                 take_irq_o,
  input logic                 req_err_o
);
  localparam logic [IDX_W-1:0] LIM = IDX_W'(NUM_LINES);

  logic tmr_hit, post_ok, post_bad, clr_bad;
  assign tmr_hit  = (count_i != '0) && (count_i == compare_i);
  assign post_ok  = post_vld_i && (post_idx_i < LIM);
  assign post_bad = post_vld_i && (post_idx_i >= LIM);
  assign clr_bad  = clr_vld_i && (clr_idx_i >= LIM);

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (pend_o == '0 && !take_irq_o));

  assert_post_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_ok && !clr_all_i && !(clr_vld_i && clr_idx_i == post_idx_i))
      |=> pend_o[$past(post_idx_i)]);

  assert_clear_all_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_all_i && !tmr_hit) |=> (pend_o == '0));

  assert_err_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_err_o |-> (post_bad || clr_bad));

  assert_bad_post_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_bad && !clr_vld_i && !clr_all_i && !tmr_hit) |=> $stable(pend_o));

  assert_timer_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_hit && (tmr_route_i < RW'(NUM_LINES - 1) || tmr_route_i == RW'(NUM_LINES - 1)))
      |=> pend_o[$past(tmr_route_i)]);

  assert_timer_clear_all_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_hit && clr_all_i) |=> ($countones(pend_o) == 1));

  assert_take_needs_unmasked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_irq_o |-> ((pend_o & im_i) != '0));

  assert_take_needs_status_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_irq_o |-> (ie_i && !erl_i && !exl_i));
endmodule

bind irq_cause_gate irq_cause_chk #(
  .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TMR_W(TMR_W), .RW(RW)
) i_irq_cause_chk (.*);

// File: tb/test_irq_cause_gate.sv
`timescale 1ns/1ps
module test_irq_cause_gate;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        post_vld_i = 1'b0;
  logic [3:0]  post_idx_i = '0;
  logic        clr_vld_i = 1'b0;
  logic [3:0]  clr_idx_i = '0;
  logic        clr_all_i = 1'b0;
  logic        ie_i = 1'b0, erl_i = 1'b0, exl_i = 1'b0;
  logic [7:0]  im_i = '0;
  logic [31:0] count_i = '0, compare_i = '0;
  logic [2:0]  tmr_route_i = '0;
  logic [7:0]  pend_o;
  logic        take_irq_o, req_err_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  irq_cause_gate i_irq_cause_gate (.*);

  always #2.5 clk_i = ~clk_i;

  typedef struct packed {
    logic        pv;
    logic [3:0]  pi;
    logic        cv;
    logic [3:0]  ci;
    logic        ca;
    logic [15:0] cnt;
    logic [15:0] cmp;
    logic [2:0]  rt;
    logic [7:0]  exp_pend;
    logic        exp_err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 4'd3,  1'b0, 4'd0,  1'b0, 16'd0, 16'd0, 3'd0, 8'h08, 1'b0, 4'd2},  // R2
    '{1'b1, 4'd0,  1'b0, 4'd0,  1'b0, 16'd0, 16'd0, 3'd0, 8'h09, 1'b0, 4'd2},  // R2
    '{1'b1, 4'd7,  1'b0, 4'd0,  1'b0, 16'd0, 16'd0, 3'd0, 8'h89, 1'b0, 4'd2},  // R2
    '{1'b0, 4'd0,  1'b1, 4'd0,  1'b0, 16'd0, 16'd0, 3'd0, 8'h88, 1'b0, 4'd3},  // R3
    '{1'b1, 4'd5,  1'b1, 4'd5,  1'b0, 16'd0, 16'd0, 3'd0, 8'h88, 1'b0, 4'd3},  // R3 clear wins
    '{1'b1, 4'd9,  1'b0, 4'd0,  1'b0, 16'd0, 16'd0, 3'd0, 8'h88, 1'b1, 4'd5},  // R5
    '{1'b0, 4'd0,  1'b1, 4'd12, 1'b0, 16'd0, 16'd0, 3'd0, 8'h88, 1'b1, 4'd5},  // R5
    '{1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 16'd5, 16'd5, 3'd1, 8'h8A, 1'b0, 4'd6},  // R6
    '{1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 16'd0, 16'd0, 3'd2, 8'h8A, 1'b0, 4'd6},  // R6 zero count
    '{1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 16'd6, 16'd7, 3'd4, 8'h8A, 1'b0, 4'd6},  // R6 no match
    '{1'b1, 4'd1,  1'b0, 4'd0,  1'b1, 16'd3, 16'd3, 3'd6, 8'h40, 1'b0, 4'd7},  // R7
    '{1'b1, 4'd2,  1'b1, 4'd6,  1'b1, 16'd0, 16'd0, 3'd0, 8'h00, 1'b0, 4'd4},  // R4
    '{1'b1, 4'd4,  1'b1, 4'd6,  1'b0, 16'd0, 16'd0, 3'd0, 8'h10, 1'b0, 4'd3}   // R3 other line
  };

  task automatic check1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic idle_req();
    post_vld_i = 1'b0; clr_vld_i = 1'b0; clr_all_i = 1'b0;
    count_i = '0; compare_i = '0;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    ie_i = 1'b1; im_i = 8'hFF;
    repeat (3) @(negedge clk_i);
    check8("R1 pend in reset", pend_o, 8'h00);
    check1("R1 take in reset", take_irq_o, 1'b0);
    rst_ni = 1'b1;
    ie_i = 1'b0; im_i = 8'h00;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk_i);
      post_vld_i = TBL[k].pv; post_idx_i = TBL[k].pi;
      clr_vld_i  = TBL[k].cv; clr_idx_i  = TBL[k].ci;
      clr_all_i  = TBL[k].ca;
      count_i    = 32'(TBL[k].cnt); compare_i = 32'(TBL[k].cmp);
      tmr_route_i = TBL[k].rt;
      #1;
      check1($sformatf("R%0d err row %0d", TBL[k].req, k), req_err_o, TBL[k].exp_err);
      @(posedge clk_i); #1;
      check8($sformatf("R%0d pend row %0d", TBL[k].req, k), pend_o, TBL[k].exp_pend);
    end

    @(negedge clk_i);
    idle_req();
    ie_i = 1'b1; erl_i = 1'b0; exl_i = 1'b0; im_i = 8'h10;
    #1 check1("R9 take open", take_irq_o, 1'b1);
    im_i = 8'hEF;
    #1 check1("R8 masked", take_irq_o, 1'b0);
    im_i = 8'h10; ie_i = 1'b0;
    #1 check1("R9 ie low", take_irq_o, 1'b0);
    ie_i = 1'b1; erl_i = 1'b1;
    #1 check1("R9 erl high", take_irq_o, 1'b0);
    erl_i = 1'b0; exl_i = 1'b1;
    #1 check1("R9 exl high", take_irq_o, 1'b0);
    exl_i = 1'b0;
    #1 check1("R8 unmasked", take_irq_o, 1'b1);

    @(negedge clk_i);
    clr_all_i = 1'b1;
    @(posedge clk_i); #1;
    check1("R8 nothing pending", take_irq_o, 1'b0);
    @(negedge clk_i);
    clr_all_i = 1'b0;
    post_vld_i = 1'b1; post_idx_i = 4'd2; im_i = 8'h04;
    #1 check1("R10 before edge", take_irq_o, 1'b0);
    @(posedge clk_i); #1;
    check1("R10 after edge", take_irq_o, 1'b1);
    check8("R10 pend", pend_o, 8'h04);

    @(negedge clk_i);
    idle_req();
    #1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule